// File: doc/BRIEF.md
# Compute Unit Workgroup Occupancy Limiter

This block works out how many workgroups of one kernel can be resident together on a single compute unit. Three inputs describe the kernel: threads per workgroup, registers per thread, and local memory bytes per workgroup. The per-unit budgets are parameters: register file size, local memory size, resident thread capacity and largest legal workgroup. Each budget is turned into a whole-workgroup count. The block reports the smallest of the three counts and a 2-bit code for the budget that binds. It also raises a flag when the kernel cannot be placed at all.

A single restoring divider is shared by the three budgets. It yields one quotient bit per cycle, and the budgets go through it one after another. A budget whose demand is zero, or whose answer is already known, skips the divider. A caller pulses `start` while the block is idle and then waits for the one-cycle `done` pulse. The results stay on the outputs until the next completion.

Top module: `occ_limiter`

## Requirements
- R1: The register count is floor(REG_CAP / (wg_size * regs_per_thread)), with REG_CAP = 16384 by default. A zero product places no register limit. Examples: 256 threads at 17 registers gives 3, and at 16 registers gives 4. 128 threads at 35 registers gives 3.
- R2: The local memory count is floor(LDS_CAP / lds_bytes), with LDS_CAP = 32768 by default. lds_bytes = 0 places no local memory limit.
- R3: The thread count is floor(THR_CAP / wg_size), with THR_CAP = 1600 by default.
- R4: A wg_size of 0, or one above MAX_WG (256 by default), sets the thread count to 0. A 512-thread group is therefore refused.
- R5: `groups` equals the minimum of the three counts. Any count above 65534 is clipped to 65534.
- R6: `limiter` names the count that gave the minimum: 0 for registers, 1 for local memory, 2 for threads. On a tie the lowest code wins, and the value 3 never appears.
- R7: `cannot_launch` is 1 exactly when at least one count is 0. In that case `groups` is 0.
- R8: A `start` seen while `busy` is low latches the inputs and raises `busy` on the next cycle. `done` is high for exactly one cycle, and `busy` drops with it. A `start` while busy is ignored. The outputs hold their values until the next completion.
- R9: After reset, `busy`, `done`, `groups`, `limiter` and `cannot_launch` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation when idle |
| wg_size | input | 9 | Threads per workgroup |
| regs_per_thread | input | 8 | Registers needed by each thread |
| lds_bytes | input | 17 | Local memory bytes per workgroup |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| groups | output | 16 | Resident workgroup count |
| limiter | output | 2 | Binding budget: 0 registers, 1 local memory, 2 threads |
| cannot_launch | output | 1 | Some budget admits no workgroup |

## Verification
Two of the block's functions can meet in a single cycle.

The first pair is the minimum choice and the tie rule. The bench reaches it with inputs where two counts are equal, such as 64 threads at 10 registers, where the register count and the thread count are both 25. It then checks that the lower code is reported.

The second pair is a new `start` and a computation already running. The bench drives a second request with different inputs while `busy` is high. It then judges that the reported result still belongs to the first request.

A near-exhaustive sweep of sizes, register counts and byte counts compares every outcome with arithmetic done in the bench.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [1:0] {
    LIM_REG = 2'd0,
    LIM_LDS = 2'd1,
    LIM_THR = 2'd2
  } lim_code_e;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_LAUNCH = 2'd1,
    S_WAIT   = 2'd2,
    S_OUT    = 2'd3
  } occ_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/occ_divider.sv
module occ_divider #(
  parameter int W = 17
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient
);
  localparam int CW = $clog2(W + 1);

  logic [W:0]    rem;
  logic [W-1:0]  quo;
  logic [W-1:0]  dsr;
  logic [W-1:0]  num;
  logic [CW-1:0] cnt;
  logic          run;
  logic [W:0]    shifted;
  logic          fits;

  always_comb begin
    shifted = {rem[W-1:0], quo[W-1]};
    fits    = (shifted >= {1'b0, dsr});
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem  <= '0;
      quo  <= '0;
      dsr  <= '0;
      num  <= '0;
      cnt  <= '0;
      run  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start && !run) begin
        rem <= '0;
        quo <= dividend;
        num <= dividend;
        dsr <= divisor;
        cnt <= CW'(W);
        run <= 1'b1;
      end else if (run) begin
        if (fits) begin
          rem <= shifted - {1'b0, dsr};
          quo <= {quo[W-2:0], 1'b1};
        end else begin
          rem <= shifted;
          quo <= {quo[W-2:0], 1'b0};
        end
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          run  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign busy     = run;
  assign quotient = quo;

  // R1 R2 R3: every budget count is an exact floor quotient
  a_r1_div_floor: assert property (@(posedge clk) disable iff (rst)
    done |-> (({{W{1'b0}}, quo} * {{W{1'b0}}, dsr} <= {{W{1'b0}}, num}) &&
              ({{W{1'b0}}, num} - {{W{1'b0}}, quo} * {{W{1'b0}}, dsr} < {{W{1'b0}}, dsr})));

  a_r8_div_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/occ_select.sv
module occ_select #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] lim_reg,
  input  logic [CNT_W-1:0] lim_lds,
  input  logic [CNT_W-1:0] lim_thr,
  output logic [CNT_W-1:0] min_cnt,
  output logic [1:0]       min_code,
  output logic             any_zero
);
  import occ_pkg::*;

  always_comb begin
    if (lim_reg <= lim_lds && lim_reg <= lim_thr) begin
      min_cnt  = lim_reg;
      min_code = LIM_REG;
    end else if (lim_lds <= lim_thr) begin
      min_cnt  = lim_lds;
      min_code = LIM_LDS;
    end else begin
      min_cnt  = lim_thr;
      min_code = LIM_THR;
    end
    any_zero = (lim_reg == '0) || (lim_lds == '0) || (lim_thr == '0);
  end
endmodule

// File: rtl/occ_limiter.sv
module occ_limiter #(
  parameter int WG_W    = 9,
  parameter int RPT_W   = 8,
  parameter int LDS_W   = 17,
  parameter int CNT_W   = 16,
  parameter int REG_CAP = 16384,
  parameter int LDS_CAP = 32768,
  parameter int THR_CAP = 1600,
  parameter int MAX_WG  = 256
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [WG_W-1:0]  wg_size,
  input  logic [RPT_W-1:0] regs_per_thread,
  input  logic [LDS_W-1:0] lds_bytes,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] groups,
  output logic [1:0]       limiter,
  output logic             cannot_launch
);
  import occ_pkg::*;

  localparam int PROD_W = WG_W + RPT_W;
  localparam int CAP_W  = $clog2(max3(REG_CAP, LDS_CAP, THR_CAP) + 1);
  localparam int DIV_W  = max3(PROD_W, LDS_W, max3(CAP_W, CNT_W + 1, 1));
  localparam int UNL    = (1 << CNT_W) - 1;
  localparam int NFAC   = 3;

  occ_state_e       state;
  logic [1:0]       idx;
  logic [WG_W-1:0]  wg_q;
  logic [RPT_W-1:0] rpt_q;
  logic [LDS_W-1:0] lds_q;
  logic [PROD_W-1:0] reg_need;
  logic [CNT_W-1:0] lim [NFAC];

  logic [DIV_W-1:0] d_num;
  logic [DIV_W-1:0] d_den;
  logic             skip;
  logic [CNT_W-1:0] skip_val;
  logic             div_start;
  logic             div_busy;
  logic             div_done;
  logic [DIV_W-1:0] div_q;
  logic [CNT_W-1:0] q_sat;

  logic [CNT_W-1:0] sel_cnt;
  logic [1:0]       sel_code;
  logic             sel_zero;

  assign reg_need = PROD_W'(wg_q) * PROD_W'(rpt_q);

  // operand and bypass choice for the factor being worked on
  always_comb begin
    d_num    = '0;
    d_den    = '0;
    skip     = 1'b0;
    skip_val = CNT_W'(UNL);
    case (idx)
      2'd0: begin
        d_num = DIV_W'(REG_CAP);
        d_den = DIV_W'(reg_need);
        skip  = (reg_need == '0);
      end
      2'd1: begin
        d_num = DIV_W'(LDS_CAP);
        d_den = DIV_W'(lds_q);
        skip  = (lds_q == '0);
      end
      default: begin
        d_num    = DIV_W'(THR_CAP);
        d_den    = DIV_W'(wg_q);
        skip     = (wg_q == '0) || (int'(wg_q) > MAX_WG);
        skip_val = '0;
      end
    endcase
  end

  always_comb begin
    if (div_q >= DIV_W'(UNL)) q_sat = CNT_W'(UNL - 1);
    else                      q_sat = div_q[CNT_W-1:0];
  end

  assign div_start = (state == S_LAUNCH) && !skip;

  occ_divider #(.W(DIV_W)) u_div (
    .clk      (clk),
    .rst      (rst),
    .start    (div_start),
    .dividend (d_num),
    .divisor  (d_den),
    .busy     (div_busy),
    .done     (div_done),
    .quotient (div_q)
  );

  occ_select #(.CNT_W(CNT_W)) u_sel (
    .lim_reg  (lim[0]),
    .lim_lds  (lim[1]),
    .lim_thr  (lim[2]),
    .min_cnt  (sel_cnt),
    .min_code (sel_code),
    .any_zero (sel_zero)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      idx           <= '0;
      wg_q          <= '0;
      rpt_q         <= '0;
      lds_q         <= '0;
      done          <= 1'b0;
      groups        <= '0;
      limiter       <= '0;
      cannot_launch <= 1'b0;
      for (int i = 0; i < NFAC; i++) lim[i] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            wg_q  <= wg_size;
            rpt_q <= regs_per_thread;
            lds_q <= lds_bytes;
            idx   <= '0;
            state <= S_LAUNCH;
          end
        end
        S_LAUNCH: begin
          if (skip) begin
            lim[idx] <= skip_val;
            if (idx == 2'(NFAC - 1)) state <= S_OUT;
            else                     idx   <= idx + 1'b1;
          end else begin
            state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (div_done) begin
            lim[idx] <= q_sat;
            if (idx == 2'(NFAC - 1)) begin
              state <= S_OUT;
            end else begin
              idx   <= idx + 1'b1;
              state <= S_LAUNCH;
            end
          end
        end
        default: begin
          groups        <= sel_cnt;
          limiter       <= sel_code;
          cannot_launch <= sel_zero;
          done          <= 1'b1;
          state         <= S_IDLE;
        end
      endcase
    end
  end

  assign busy = (state != S_IDLE);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  a_r8_start_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  a_r5_min_bound: assert property (@(posedge clk) disable iff (rst)
    done |-> (groups <= lim[0] && groups <= lim[1] && groups <= lim[2]));

  a_r6_code_range: assert property (@(posedge clk) disable iff (rst)
    done |-> (limiter != 2'd3));

  a_r7_zero_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (cannot_launch == (groups == '0)));

  a_r4_reject: assert property (@(posedge clk) disable iff (rst)
    (done && (wg_q == '0 || int'(wg_q) > MAX_WG)) |-> cannot_launch);

  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (!done && !$past(rst)) |-> $stable(groups));
endmodule

// File: tb/test_occ_limiter.sv
module test_occ_limiter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [8:0]  wg_size = '0;
  logic [7:0]  regs_per_thread = '0;
  logic [16:0] lds_bytes = '0;
  logic        busy;
  logic        done;
  logic [15:0] groups;
  logic [1:0]  limiter;
  logic        cannot_launch;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  occ_limiter i_occ_limiter (
    .clk             (clk),
    .rst             (rst),
    .start           (start),
    .wg_size         (wg_size),
    .regs_per_thread (regs_per_thread),
    .lds_bytes       (lds_bytes),
    .busy            (busy),
    .done            (done),
    .groups          (groups),
    .limiter         (limiter),
    .cannot_launch   (cannot_launch)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // expected values from the requirement arithmetic
  task automatic model(input int wg, input int rpt, input int lds,
                       output int g, output int code, output int cl);
    int lr, ll, lt;
    lr = (wg * rpt == 0) ? 65535 : 16384 / (wg * rpt);   // R1
    ll = (lds == 0) ? 65535 : 32768 / lds;                // R2
    lt = (wg == 0 || wg > 256) ? 0 : 1600 / wg;           // R3 R4
    if (lr > 65534 && lr != 65535) lr = 65534;
    if (ll > 65534 && ll != 65535) ll = 65534;
    if (lr <= ll && lr <= lt) begin g = lr; code = 0; end  // R5 R6
    else if (ll <= lt)        begin g = ll; code = 1; end
    else                      begin g = lt; code = 2; end
    cl = (lr == 0 || ll == 0 || lt == 0) ? 1 : 0;          // R7
  endtask

  task automatic wait_done(output bit ok);
    ok = 1'b0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (done) begin ok = 1'b1; break; end
    end
  endtask

  task automatic run_one(input int wg, input int rpt, input int lds);
    int g, code, cl;
    bit ok;
    @(negedge clk);
    wg_size = 9'(wg); regs_per_thread = 8'(rpt); lds_bytes = 17'(lds);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check(ok, "R8 done timeout", 0, 1);
    model(wg, rpt, lds, g, code, cl);
    check(int'(groups) == g, $sformatf("R5 groups wg=%0d r=%0d l=%0d", wg, rpt, lds), groups, g);
    check(int'(limiter) == code, $sformatf("R6 code wg=%0d r=%0d l=%0d", wg, rpt, lds), limiter, code);
    check(int'(cannot_launch) == cl, $sformatf("R7 flag wg=%0d r=%0d l=%0d", wg, rpt, lds), cannot_launch, cl);
  endtask

  initial begin
    #4_000_000;
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int wgs[16]  = '{0, 1, 2, 3, 5, 16, 63, 64, 100, 128, 200, 255, 256, 257, 300, 511};
    int rpts[7]  = '{0, 1, 7, 16, 17, 35, 255};
    int ldss[6]  = '{0, 1, 999, 4096, 32768, 131071};
    int g0;
    bit ok;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(busy == 1'b0, "R9 busy", busy, 0);
    check(done == 1'b0, "R9 done", done, 0);
    check(groups == '0, "R9 groups", groups, 0);
    check(limiter == '0, "R9 limiter", limiter, 0);
    check(cannot_launch == 1'b0, "R9 flag", cannot_launch, 0);

    // R1 worked examples
    run_one(256, 17, 0);
    check(groups == 16'd3, "R1 256x17", groups, 3);
    run_one(256, 16, 0);
    check(groups == 16'd4, "R1 256x16", groups, 4);
    run_one(128, 35, 0);
    check(groups == 16'd3, "R1 128x35", groups, 3);
    run_one(256, 35, 0);
    check(groups == 16'd1, "R1 256x35", groups, 1);
    // R4 oversize refused
    run_one(511, 1, 0);
    check(cannot_launch == 1'b1, "R4 oversize", cannot_launch, 1);
    // R2 local memory binds
    run_one(16, 1, 8192);
    check(groups == 16'd4 && limiter == 2'd1, "R2 lds bind", groups, 4);
    // R3 thread binds
    run_one(128, 1, 100);
    check(groups == 16'd12 && limiter == 2'd2, "R3 thr bind", groups, 12);
    // R6 tie between registers and threads
    run_one(64, 10, 0);
    check(groups == 16'd25 && limiter == 2'd0, "R6 tie", limiter, 0);

    // R8 done is one cycle and outputs hold
    @(negedge clk);
    check(done == 1'b0, "R8 pulse width", done, 0);
    g0 = groups;
    repeat (5) @(negedge clk);
    check(int'(groups) == g0 && !busy, "R8 hold", groups, g0);

    // R8 start while busy is ignored
    @(negedge clk);
    wg_size = 9'd256; regs_per_thread = 8'd17; lds_bytes = '0;
    start = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R8 busy after start", busy, 1);
    wg_size = 9'd1; regs_per_thread = 8'd1; lds_bytes = 17'd1;
    @(negedge clk);
    start = 1'b0;
    wait_done(ok);
    check(ok, "R8 done timeout", 0, 1);
    check(groups == 16'd3 && limiter == 2'd0, "R8 ignored start", groups, 3);
    @(negedge clk);
    check(busy == 1'b0, "R8 idle after done", busy, 0);

    // near-exhaustive sweep: R1 R2 R3 R4 R5 R6 R7
    foreach (wgs[a])
      foreach (rpts[b])
        foreach (ldss[c])
          run_one(wgs[a], rpts[b], ldss[c]);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule